// File: doc/BRIEF.md
# Multi-Queue Status Ring Writer

This block keeps a set of independent circular status queues. The hardware fills these queues and a host drains them. The host sets up each queue with four items: a word-aligned base address, a flag that picks the target address space (host bus memory or local shared memory), a two-bit depth code and a read index. When a segmentation engine offers a status word for a queue, the block first works out where the next entry goes. It then issues one memory write for that entry, moves the queue's write index forward and wraps it at the queue depth.

When a write takes the last free slot, the entry goes out with its overflow bit set and the queue's blocked flag is raised. The segmentation engine uses the blocked flags to stall every channel that reports on that queue. Queues that are not in overflow keep running. A blocked queue turns away further posts until the host moves that queue's read index forward.

Top module: `srw_ring_writer`

## Requirements
- R1: After reset, every queue has base 0, space flag 0, depth code 0, write index 0, read index 0 and is not blocked. `mem_valid` is 0.
- R2: A configuration write (`cfg_we`) to a queue stores the base word `cfg_base[ADDR_W-1:2]`, the space flag and the depth code. It also clears that queue's write index, read index and blocked flag. Bits 1:0 of `cfg_base` are ignored.
- R3: On the clock edge after an accepted post, `mem_valid` is 1. `mem_addr` equals the queue base plus the write index times `ENTRY_BYTES` (4), so it is always word aligned. `mem_local` equals the queue's space flag.
- R4: The depth code selects the queue depth: 0 gives 64 entries, 1 gives 256, 2 gives 1024 and 3 gives 4096. The write index steps by one for each accepted post and wraps from depth-1 to 0.
- R5: Overflow occurs when the slot being written equals (read index - 1) modulo the depth. In that case bit `OVFL_BIT` (31) of `mem_data` is 1. Otherwise that bit is 0. All other bits of `mem_data` copy `post_data`.
- R6: A post that overflows sets that queue's bit in `q_blocked` on the same edge that writes the entry. While the bit is set, `post_ready` is 0 for that queue. All other queues still accept posts.
- R7: A refused post (`post_valid` with `post_ready` 0) issues no memory write and leaves the queue's write index unchanged.
- R8: A read-index write (`rdx_we`) stores the value masked to the queue depth. If the queue is blocked and the value differs from the stored read index, the blocked flag clears on the next clock. If the value is the same, the queue stays blocked.
- R9: `post_ready` is 0 in any cycle where `cfg_we` or `rdx_we` targets the queue named by `post_qid`.
- R10: `mon_widx` shows, without delay, the write index of the queue named by `mon_qid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Queue configuration write strobe |
| cfg_qid | input | QID_W (5) | Queue selected by the configuration write |
| cfg_base | input | ADDR_W (32) | Queue base address; bits 1:0 ignored |
| cfg_local | input | 1 | Space flag: 0 host bus memory, 1 local shared memory |
| cfg_size | input | 2 | Depth code |
| rdx_we | input | 1 | Host read-index write strobe |
| rdx_qid | input | QID_W (5) | Queue selected by the read-index write |
| rdx_val | input | 12 | New host read index |
| post_valid | input | 1 | Status post request |
| post_qid | input | QID_W (5) | Target queue of the post |
| post_data | input | DATA_W (32) | Status word to write |
| post_ready | output | 1 | Post is accepted this cycle |
| mem_valid | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W (32) | Memory write address |
| mem_local | output | 1 | Address space of the write |
| mem_data | output | DATA_W (32) | Status word with the overflow bit filled in |
| q_blocked | output | NUM_Q (32) | Per-queue blocked flags |
| mon_qid | input | QID_W (5) | Queue whose write index is shown |
| mon_widx | output | 12 | Write index of `mon_qid` |

## Verification
The assertions check four rules on every cycle. An accepted post always produces a write on the next edge, and a refused post never does. Every address is word aligned. A blocked queue never reports ready. Each queue's blocked flag rises only together with a write that carries the overflow bit, and falls only after a host write to that same queue. Some behaviour needs the bench's scenarios, because a property alone cannot confirm it. This covers exact address arithmetic, wrap points for each depth code, overflow placed at a nonzero read index, the same-value read-index write that must leave a queue blocked, and the isolation of other queues while one is blocked.

// File: rtl/srw_pkg.sv
package srw_pkg;
   localparam int SZ_W     = 2;
   localparam int IDX_W    = 12;
   localparam int MIN_LOG2 = 6;

   typedef logic [IDX_W-1:0] idx_t;

   typedef struct packed {
      logic            loc;
      logic [SZ_W-1:0] size;
      idx_t            widx;
      idx_t            ridx;
      logic            blk;
   } qstate_t;

   function automatic idx_t depth_mask(input logic [SZ_W-1:0] code);
      return idx_t'((1 << (MIN_LOG2 + 2 * int'(code))) - 1);
   endfunction
endpackage

// File: rtl/srw_ovf_detect.sv
module srw_ovf_detect
   import srw_pkg::*;
(
   input  logic [SZ_W-1:0] size_code,
   input  idx_t            widx,
   input  idx_t            ridx,
   output idx_t            slot,
   output idx_t            next_widx,
   output logic            ovf
);
   idx_t mask;

   assign mask      = depth_mask(size_code);
   assign slot      = widx & mask;
   assign next_widx = (slot + idx_t'(1)) & mask;
   assign ovf       = (slot == ((ridx - idx_t'(1)) & mask));
endmodule

// File: rtl/srw_addr_gen.sv
module srw_addr_gen
   import srw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-3:0] base_word,
   input  idx_t              slot,
   output logic [ADDR_W-1:0] addr
);
   localparam bit POW2  = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
   localparam int SHIFT = $clog2(ENTRY_BYTES);

   logic [ADDR_W-1:0] offset;

   generate
      if (POW2) begin : g_shift
         assign offset = ADDR_W'(slot) << SHIFT;
      end else begin : g_mul
         assign offset = ADDR_W'(slot) * ADDR_W'(ENTRY_BYTES);
      end
   endgenerate

   assign addr = {base_word, 2'b00} + offset;
endmodule

// File: rtl/srw_queue_table.sv
module srw_queue_table
   import srw_pkg::*;
#(
   parameter int NUM_Q  = 32,
   parameter int ADDR_W = 32,
   localparam int QID_W = $clog2(NUM_Q)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [QID_W-1:0]  cfg_qid,
   input  logic [ADDR_W-3:0] cfg_base_word,
   input  logic              cfg_local,
   input  logic [SZ_W-1:0]   cfg_size,
   input  logic              rdx_we,
   input  logic [QID_W-1:0]  rdx_qid,
   input  idx_t              rdx_val,
   input  logic              acc_we,
   input  logic [QID_W-1:0]  acc_qid,
   input  idx_t              acc_widx,
   input  logic              acc_ovf,
   output qstate_t           q_state [NUM_Q],
   output logic [ADDR_W-3:0] q_base  [NUM_Q]
);
   generate
      for (genvar i = 0; i < NUM_Q; i++) begin : g_q
         qstate_t           st;
         logic [ADDR_W-3:0] base;
         idx_t              new_ridx;

         assign new_ridx   = rdx_val & depth_mask(st.size);
         assign q_state[i] = st;
         assign q_base[i]  = base;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st   <= '0;
               base <= '0;
            end else if (cfg_we && cfg_qid == QID_W'(i)) begin
               base    <= cfg_base_word;
               st.loc  <= cfg_local;
               st.size <= cfg_size;
               st.widx <= '0;
               st.ridx <= '0;
               st.blk  <= 1'b0;
            end else begin
               if (rdx_we && rdx_qid == QID_W'(i)) begin
                  st.ridx <= new_ridx;
                  if (st.blk && new_ridx != st.ridx) st.blk <= 1'b0;
               end
               if (acc_we && acc_qid == QID_W'(i)) begin
                  st.widx <= acc_widx;
                  if (acc_ovf) st.blk <= 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/srw_ring_writer.sv
module srw_ring_writer
   import srw_pkg::*;
#(
   parameter int NUM_Q       = 32,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int ENTRY_BYTES = 4,
   parameter int OVFL_BIT    = 31,
   localparam int QID_W      = $clog2(NUM_Q)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [QID_W-1:0]  cfg_qid,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              cfg_local,
   input  logic [1:0]        cfg_size,
   input  logic              rdx_we,
   input  logic [QID_W-1:0]  rdx_qid,
   input  logic [11:0]       rdx_val,
   input  logic              post_valid,
   input  logic [QID_W-1:0]  post_qid,
   input  logic [DATA_W-1:0] post_data,
   output logic              post_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_local,
   output logic [DATA_W-1:0] mem_data,
   output logic [NUM_Q-1:0]  q_blocked,
   input  logic [QID_W-1:0]  mon_qid,
   output logic [11:0]       mon_widx
);
   if (NUM_Q < 2 || NUM_Q > 32 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_bad_nq
      $error("NUM_Q must be a power of two from 2 to 32");
   end
   if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_aw
      $error("ADDR_W must lie in 16..64");
   end
   if (ENTRY_BYTES < 4 || (ENTRY_BYTES % 4) != 0) begin : g_bad_eb
      $error("ENTRY_BYTES must be a multiple of 4");
   end
   if (OVFL_BIT < 0 || OVFL_BIT >= DATA_W) begin : g_bad_ob
      $error("OVFL_BIT must lie inside the status word");
   end

   qstate_t           q_state [NUM_Q];
   logic [ADDR_W-3:0] q_base  [NUM_Q];
   qstate_t           cur;
   idx_t              slot, nxt_widx;
   logic              ovf, host_hit, accept;
   logic [ADDR_W-1:0] entry_addr;
   logic [DATA_W-1:0] word;
   logic [1:0]        unused_cfg_low;

   assign unused_cfg_low = cfg_base[1:0];
   assign cur            = q_state[post_qid];

   srw_queue_table #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_table (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_qid       (cfg_qid),
      .cfg_base_word (cfg_base[ADDR_W-1:2]),
      .cfg_local     (cfg_local),
      .cfg_size      (cfg_size),
      .rdx_we        (rdx_we),
      .rdx_qid       (rdx_qid),
      .rdx_val       (rdx_val),
      .acc_we        (accept),
      .acc_qid       (post_qid),
      .acc_widx      (nxt_widx),
      .acc_ovf       (ovf),
      .q_state       (q_state),
      .q_base        (q_base)
   );

   srw_ovf_detect u_ovf (
      .size_code (cur.size),
      .widx      (cur.widx),
      .ridx      (cur.ridx),
      .slot      (slot),
      .next_widx (nxt_widx),
      .ovf       (ovf)
   );

   srw_addr_gen #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
      .base_word (q_base[post_qid]),
      .slot      (slot),
      .addr      (entry_addr)
   );

   assign host_hit   = (cfg_we && cfg_qid == post_qid) || (rdx_we && rdx_qid == post_qid);
   assign post_ready = !cur.blk && !host_hit;
   assign accept     = post_valid && post_ready;

   always_comb begin
      word           = post_data;
      word[OVFL_BIT] = ovf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_addr  <= '0;
         mem_local <= 1'b0;
         mem_data  <= '0;
      end else begin
         mem_valid <= accept;
         if (accept) begin
            mem_addr  <= entry_addr;
            mem_local <= cur.loc;
            mem_data  <= word;
         end
      end
   end

   generate
      for (genvar i = 0; i < NUM_Q; i++) begin : g_blk
         assign q_blocked[i] = q_state[i].blk;
      end
   endgenerate

   assign mon_widx = q_state[mon_qid].widx;
endmodule

// File: rtl/srw_ring_writer_chk.sv
module srw_ring_writer_chk #(
   parameter int NUM_Q    = 32,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int OVFL_BIT = 31,
   localparam int QID_W   = $clog2(NUM_Q)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [QID_W-1:0]  cfg_qid,
   input logic              rdx_we,
   input logic [QID_W-1:0]  rdx_qid,
   input logic              post_valid,
   input logic [QID_W-1:0]  post_qid,
   input logic              post_ready,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic [NUM_Q-1:0]  q_blocked
);
   p_accept_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && post_ready |=> mem_valid);

   p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr[1:0] == 2'b00);

   p_refused_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && !post_ready |=> !mem_valid);

   p_blocked_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && q_blocked[post_qid] |-> !post_ready);

   generate
      for (genvar i = 0; i < NUM_Q; i++) begin : g_q
         p_block_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q_blocked[i]) |-> mem_valid && mem_data[OVFL_BIT]);

         p_release_by_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q_blocked[i]) |->
               $past((rdx_we && rdx_qid == QID_W'(i)) || (cfg_we && cfg_qid == QID_W'(i))));
      end
   endgenerate
endmodule

bind srw_ring_writer srw_ring_writer_chk #(
   .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVFL_BIT(OVFL_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_qid    (cfg_qid),
   .rdx_we     (rdx_we),
   .rdx_qid    (rdx_qid),
   .post_valid (post_valid),
   .post_qid   (post_qid),
   .post_ready (post_ready),
   .mem_valid  (mem_valid),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .q_blocked  (q_blocked)
);

// File: tb/tb_srw_ring_writer.sv
module tb_srw_ring_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_qid = '0;
   logic [31:0] cfg_base = '0;
   logic        cfg_local = 1'b0;
   logic [1:0]  cfg_size = '0;
   logic        rdx_we = 1'b0;
   logic [4:0]  rdx_qid = '0;
   logic [11:0] rdx_val = '0;
   logic        post_valid = 1'b0;
   logic [4:0]  post_qid = '0;
   logic [31:0] post_data = '0;
   logic        post_ready;
   logic        mem_valid;
   logic [31:0] mem_addr;
   logic        mem_local;
   logic [31:0] mem_data;
   logic [31:0] q_blocked;
   logic [4:0]  mon_qid = '0;
   logic [11:0] mon_widx;

   int checks = 0;
   int fails  = 0;

   logic        c_rdy, c_val, c_loc;
   logic [31:0] c_addr, c_data;

   always #4 clk = ~clk;

   srw_ring_writer dut (.*);

   typedef struct packed {
      logic [4:0]  qid;
      logic [31:0] data;
      logic [31:0] eaddr;
      logic [31:0] edata;
      logic        eloc;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{5'd3,  32'h0000_00A5, 32'h1000_0000, 32'h0000_00A5, 1'b1},
      '{5'd3,  32'h8000_0001, 32'h1000_0004, 32'h0000_0001, 1'b1},
      '{5'd7,  32'h1234_5678, 32'h2000_0100, 32'h1234_5678, 1'b0},
      '{5'd31, 32'hFFFF_FFFF, 32'h0000_8000, 32'h7FFF_FFFF, 1'b0},
      '{5'd7,  32'hCAFE_F00D, 32'h2000_0104, 32'h4AFE_F00D, 1'b0},
      '{5'd3,  32'h0000_0003, 32'h1000_0008, 32'h0000_0003, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_cfg(input logic [4:0] q, input logic [31:0] b, input logic l, input logic [1:0] s);
      @(negedge clk);
      cfg_we = 1'b1; cfg_qid = q; cfg_base = b; cfg_local = l; cfg_size = s;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic do_rdx(input logic [4:0] q, input logic [11:0] v);
      @(negedge clk);
      rdx_we = 1'b1; rdx_qid = q; rdx_val = v;
      @(posedge clk); #1;
      rdx_we = 1'b0;
   endtask

   task automatic do_post(input logic [4:0] q, input logic [31:0] d);
      @(negedge clk);
      post_valid = 1'b1; post_qid = q; post_data = d;
      #1 c_rdy = post_ready;
      @(posedge clk); #1;
      post_valid = 1'b0;
      c_val = mem_valid; c_addr = mem_addr; c_loc = mem_local; c_data = mem_data;
   endtask

   task automatic read_widx(input logic [4:0] q, output logic [11:0] w);
      mon_qid = q; #1 w = mon_widx;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [11:0] w;
      logic        bad;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 blocked", q_blocked, 32'h0);
      check("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
      read_widx(5'd9, w);
      check("R1 widx", {20'h0, w}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      do_cfg(5'd3,  32'h1000_0000, 1'b1, 2'd0);
      do_cfg(5'd7,  32'h2000_0103, 1'b0, 2'd1);
      do_cfg(5'd31, 32'h0000_8000, 1'b0, 2'd2);

      // R3 / R5 vector table
      for (int i = 0; i < NV; i++) begin
         do_post(VEC[i].qid, VEC[i].data);
         check("R3 valid", {31'h0, c_val}, 32'h1);
         check("R3 addr", c_addr, VEC[i].eaddr);
         check("R3 local", {31'h0, c_loc}, {31'h0, VEC[i].eloc});
         check("R5 data", c_data, VEC[i].edata);
      end

      // R4 / R5 / R6: fill q3 (depth 64) from slot 3 up to slot 63
      bad = 1'b0;
      for (int i = 3; i < 63; i++) begin
         do_post(5'd3, 32'h0);
         if (!c_val || c_data[31] || c_addr != 32'h1000_0000 + 32'(i) * 4) bad = 1'b1;
      end
      check("R5 no early overflow", {31'h0, bad}, 32'h0);
      do_post(5'd3, 32'h0000_0055);
      check("R3 last slot addr", c_addr, 32'h1000_00FC);
      check("R5 overflow bit", c_data, 32'h8000_0055);
      check("R6 blocked", q_blocked, 32'h0000_0008);
      read_widx(5'd3, w);
      check("R4 wrap 64", {20'h0, w}, 32'h0);

      // R7: refused post
      do_post(5'd3, 32'h1);
      check("R7 not ready", {31'h0, c_rdy}, 32'h0);
      check("R7 no write", {31'h0, c_val}, 32'h0);
      read_widx(5'd3, w);
      check("R7 widx kept", {20'h0, w}, 32'h0);
      // R6: other queue still runs
      do_post(5'd7, 32'h2);
      check("R6 other ready", {31'h0, c_rdy}, 32'h1);
      check("R6 other addr", c_addr, 32'h2000_0108);

      // R8: same read index keeps block, new one releases
      do_rdx(5'd3, 12'd0);
      check("R8 same keeps", q_blocked, 32'h0000_0008);
      do_rdx(5'd3, 12'd10);
      check("R8 release", q_blocked, 32'h0);
      do_post(5'd3, 32'h4);
      check("R8 resumes addr", c_addr, 32'h1000_0000);
      check("R8 resumes no ovf", {31'h0, c_data[31]}, 32'h0);

      // R4: q7 depth 256 wraps without overflow, then overflows at slot 2
      do_rdx(5'd7, 12'd3);
      bad = 1'b0;
      for (int i = 3; i < 256; i++) begin
         do_post(5'd7, 32'h0);
         if (!c_val || c_data[31] || c_addr != 32'h2000_0100 + 32'(i) * 4) bad = 1'b1;
      end
      check("R4 fill 256", {31'h0, bad}, 32'h0);
      read_widx(5'd7, w);
      check("R4 wrap 256", {20'h0, w}, 32'h0);
      do_post(5'd7, 32'h0);
      check("R4 after wrap addr", c_addr, 32'h2000_0100);
      do_post(5'd7, 32'h0);
      check("R5 no ovf slot1", {31'h0, c_data[31]}, 32'h0);
      do_post(5'd7, 32'h0);
      check("R5 ovf at rd-1", c_data, 32'h8000_0000);
      check("R6 q7 blocked", q_blocked, 32'h0000_0080);

      // R2: reconfigure clears state
      do_cfg(5'd7, 32'h3000_0002, 1'b1, 2'd0);
      check("R2 unblock", q_blocked, 32'h0);
      read_widx(5'd7, w);
      check("R2 widx clear", {20'h0, w}, 32'h0);
      do_post(5'd7, 32'h9);
      check("R2 new base", c_addr, 32'h3000_0000);
      check("R2 new local", {31'h0, c_loc}, 32'h1);

      // R5: overflow with nonzero read index on depth 1024
      do_rdx(5'd31, 12'd5);
      for (int i = 1; i < 4; i++) do_post(5'd31, 32'h0);
      check("R5 q31 no ovf", {31'h0, c_data[31]}, 32'h0);
      do_post(5'd31, 32'h0);
      check("R5 q31 addr", c_addr, 32'h0000_8010);
      check("R5 q31 ovf", {31'h0, c_data[31]}, 32'h1);
      check("R6 q31 only", q_blocked, 32'h8000_0000);

      // R9: host write to same queue refuses post
      @(negedge clk);
      rdx_we = 1'b1; rdx_qid = 5'd3; rdx_val = 12'd10;
      post_valid = 1'b1; post_qid = 5'd3; post_data = 32'h0;
      #1 check("R9 ready low", {31'h0, post_ready}, 32'h0);
      @(posedge clk); #1;
      rdx_we = 1'b0; post_valid = 1'b0;
      check("R9 no write", {31'h0, mem_valid}, 32'h0);
      read_widx(5'd3, w);
      check("R10 widx q3", {20'h0, w}, 32'h1);

      // R4: depth 4096
      do_cfg(5'd0, 32'h4000_0000, 1'b0, 2'd3);
      bad = 1'b0;
      for (int i = 0; i < 4095; i++) begin
         do_post(5'd0, 32'h0);
         if (!c_val || c_data[31]) bad = 1'b1;
      end
      check("R4 fill 4096", {31'h0, bad}, 32'h0);
      read_widx(5'd0, w);
      check("R10 widx 4095", {20'h0, w}, 32'h0000_0FFF);
      do_post(5'd0, 32'h0);
      check("R4 last 4096 addr", c_addr, 32'h4000_3FFC);
      check("R5 ovf 4096", {31'h0, c_data[31]}, 32'h1);
      read_widx(5'd0, w);
      check("R4 wrap 4096", {20'h0, w}, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule